// File: doc/BRIEF.md
# Speculative Completion Delay Selector

This block is a clocked timing model for a single-rail function unit whose result is flagged valid by a separate done line. A fixed matched delay would have to cover the slowest logic path on every operation. This block instead holds a small bank of delays, measured in clock cycles, and picks one per operation. Each operation starts at the shortest tier. It climbs one tier per cycle until it reaches the tier that the operand's slow-case flags call for. It then counts that tier's delay and raises done.

The requester uses a four-phase handshake. It raises `req_i` with a data word and its slow-case flags. It keeps `req_i` high until `done_o` rises, then drops it. `done_o` acts as the acknowledge. It stays high until the block sees `req_i` low, then falls. Back-pressure is implicit: a new request is taken only after `done_o` has fallen. While an operation is in flight, the source is free to change `data_i` and `slow_i`. The delay bank can be rewritten from a plain write port while the block is idle. Writes that would leave the bank non-monotonic, or that hold a zero delay, are dropped.

Top module: `spec_done_sel`

## Requirements
- R1: After reset, `done_o` is 0, `tier_o` is 0 and `data_o` is 0. The delay bank holds 2, 4, 6 and 8 cycles for tiers 0 to 3.
- R2: `data_i` is captured on the clock edge that accepts a request. `data_o` keeps that value until `done_o` has fallen, whatever `data_i` does meanwhile.
- R3: With no slow-case flag set, `tier_o` stays 0. `done_o` rises exactly 1 + D0 clock edges after the accepting edge, where D0 is the tier-0 delay.
- R4: Bit j-1 of `slow_i` requests tier j or higher (j = 1..3). The target tier is the highest such j. `tier_o` climbs by one per cycle to the target, and `done_o` rises exactly target + 1 + Dtarget edges after the accepting edge.
- R5: `slow_i` is sampled only on the accepting edge. Later changes do not alter the tier or the latency.
- R6: `done_o` stays high while `req_i` is high. On the first edge that sees `req_i` low, `done_o` falls and `tier_o` returns to 0.
- R7: A table write (`tbl_we_i`, index `tbl_sel_i`, value `tbl_val_i`) issued while idle sets that tier's delay for later operations.
- R8: A write is ignored if its value is 0, or is below the entry of the next lower tier, or is above the entry of the next higher tier.
- R9: A write issued while an operation is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Four-phase request |
| data_i | input | DATA_W | Operand word, single-rail |
| slow_i | input | TIERS-1 | Slow-case flags; bit j-1 asks for tier j or higher |
| done_o | output | 1 | Completion / acknowledge |
| data_o | output | DATA_W | Word captured with the request |
| tier_o | output | log2(TIERS) | Delay tier currently selected |
| tbl_we_i | input | 1 | Delay bank write strobe |
| tbl_sel_i | input | log2(TIERS) | Tier index to write |
| tbl_val_i | input | CNT_W | New delay in cycles |

## Verification
The hardest case is an operation whose inputs change after acceptance. This means flags and data that move while the tier is still climbing, and a bank write that lands mid-flight. Neither shows up at the ports except through the exact cycle `done_o` rises. The stimulus therefore inverts `data_i` and `slow_i` one cycle after the request is accepted. It also fires a bank write while a tier-3 operation is still escalating. The scoreboard then checks the exact completion cycle of that operation and of the following operation against a model of the bank that skips rejected writes.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CLIMB = 2'd1,
    S_COUNT = 2'd2,
    S_DONE  = 2'd3
  } spd_state_e;
endpackage

// File: rtl/spd_delay_bank.sv
module spd_delay_bank #(
  parameter int TIERS = 4,
  parameter int CNT_W = 8,
  parameter int BASE  = 2,
  localparam int TW   = $clog2(TIERS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TW-1:0]    wr_sel,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [TW-1:0]    rd_sel,
  output logic [CNT_W-1:0] rd_val
);
  logic [CNT_W-1:0] tbl [TIERS];

  for (genvar i = 0; i < TIERS; i++) begin : g_entry
    logic lo_ok, hi_ok, hit;
    if (i == 0) begin : g_first
      assign lo_ok = 1'b1;
    end else begin : g_lower
      assign lo_ok = (wr_val >= tbl[i-1]);
    end
    if (i == TIERS-1) begin : g_last
      assign hi_ok = 1'b1;
    end else begin : g_upper
      assign hi_ok = (wr_val <= tbl[i+1]);
    end
    assign hit = wr_en && (wr_sel == TW'(i)) && (wr_val != '0) && lo_ok && hi_ok;

    always_ff @(posedge clk) begin
      if (!rst_n)   tbl[i] <= CNT_W'(BASE * (i + 1));
      else if (hit) tbl[i] <= wr_val;
    end

    p_no_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tbl[i] != '0);

    if (i < TIERS-1) begin : g_order
      p_table_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tbl[i] <= tbl[i+1]);
    end
  end

  assign rd_val = tbl[rd_sel];
endmodule

// File: rtl/spd_tier_sel.sv
module spd_tier_sel #(
  parameter int TIERS = 4,
  localparam int TW   = $clog2(TIERS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             clear,
  input  logic             step,
  input  logic [TIERS-2:0] flags,
  output logic [TW-1:0]    tier,
  output logic             settled
);
  logic [TW-1:0] need_d, need_q, tier_q;

  always_comb begin
    need_d = '0;
    for (int j = 1; j < TIERS; j++) begin
      if (flags[j-1]) need_d = TW'(j);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      need_q <= '0;
      tier_q <= '0;
    end else if (capture) begin
      need_q <= need_d;
      tier_q <= '0;
    end else if (clear) begin
      need_q <= '0;
      tier_q <= '0;
    end else if (step && (tier_q < need_q)) begin
      tier_q <= tier_q + TW'(1);
    end
  end

  assign tier    = tier_q;
  assign settled = (tier_q == need_q);

  p_tier_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tier_q <= need_q);
  p_tier_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !clear) |=> (tier_q == $past(tier_q)) || (tier_q == TW'($past(tier_q) + 1'b1)));
  p_need_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !clear) |=> $stable(need_q));
endmodule

// File: rtl/spd_countdown.sv
module spd_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt_q <= CNT_W'(1);
    else if (load)                      cnt_q <= load_val;
    else if (run && cnt_q > CNT_W'(1))  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last = run && (cnt_q == CNT_W'(1));

  p_cnt_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q != '0);
  p_cnt_descend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/spec_done_sel.sv
module spec_done_sel #(
  parameter int DATA_W = 16,
  parameter int TIERS  = 4,
  parameter int CNT_W  = 8,
  parameter int BASE   = 2,
  localparam int TW    = $clog2(TIERS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TIERS-2:0]  slow_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic [TW-1:0]     tier_o,
  input  logic              tbl_we_i,
  input  logic [TW-1:0]     tbl_sel_i,
  input  logic [CNT_W-1:0]  tbl_val_i
);
  import spd_pkg::*;

  spd_state_e        state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic              capture, clear, step, load, last, settled;
  logic [TW-1:0]     tier;
  logic [CNT_W-1:0]  delay;

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    clear   = 1'b0;
    step    = 1'b0;
    load    = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_i) begin
        capture = 1'b1;
        state_d = S_CLIMB;
      end
      S_CLIMB: begin
        step = 1'b1;
        if (settled) begin
          load    = 1'b1;
          state_d = S_COUNT;
        end
      end
      S_COUNT: if (last) state_d = S_DONE;
      S_DONE: if (!req_i) begin
        clear   = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (capture) data_q <= data_i;
    end
  end

  spd_delay_bank #(.TIERS(TIERS), .CNT_W(CNT_W), .BASE(BASE)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tbl_we_i && (state_q == S_IDLE)),
    .wr_sel (tbl_sel_i),
    .wr_val (tbl_val_i),
    .rd_sel (tier),
    .rd_val (delay)
  );

  spd_tier_sel #(.TIERS(TIERS)) u_tier (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .clear   (clear),
    .step    (step),
    .flags   (slow_i),
    .tier    (tier),
    .settled (settled)
  );

  spd_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (delay),
    .run      (state_q == S_COUNT),
    .last     (last)
  );

  assign done_o = (state_q == S_DONE);
  assign data_o = data_q;
  assign tier_o = tier;

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && req_i) |=> done_o);
  p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !req_i) |=> (!done_o && tier_o == '0));
  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> $stable(data_o));
  p_done_only_after_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(state_q) == S_COUNT);
endmodule

// File: tb/spec_done_sel_test.sv
module spec_done_sel_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [2:0]    slow_i = '0;
  logic          tbl_we_i = 1'b0;
  logic [1:0]    tbl_sel_i = '0;
  logic [7:0]    tbl_val_i = '0;
  logic          done_o;
  logic [DW-1:0] data_o;
  logic [1:0]    tier_o;

  always #10 clk = ~clk;

  spec_done_sel uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .data_i(data_i), .slow_i(slow_i),
    .done_o(done_o), .data_o(data_o), .tier_o(tier_o),
    .tbl_we_i(tbl_we_i), .tbl_sel_i(tbl_sel_i), .tbl_val_i(tbl_val_i)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  int m_tbl [4] = '{2, 4, 6, 8};

  typedef struct {
    logic [DW-1:0] d;
    int            tier;
    int            at;
    string         tag;
  } exp_t;
  exp_t sb [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int target(input logic [2:0] f);
    int t = 0;
    for (int j = 1; j < 4; j++) if (f[j-1]) t = j;
    return t;
  endfunction

  function automatic bit legal(input int idx, input int v);
    if (v == 0) return 0;
    if (idx > 0 && v < m_tbl[idx-1]) return 0;
    if (idx < 3 && v > m_tbl[idx+1]) return 0;
    return 1;
  endfunction

  // monitor: pops one expectation per rising done
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && done_o && !prev_done) begin
      if (sb.size() == 0) check(0, "R6", "unexpected done", 1, 0);
      else begin
        e = sb.pop_front();
        check(cyc == e.at, e.tag, "done cycle", cyc, e.at);
        check(data_o == e.d, "R2", "captured data", data_o, e.d);
        check(int'(tier_o) == e.tier, e.tag, "tier at done", tier_o, e.tier);
      end
    end
    prev_done <= done_o;
  end

  task automatic wr_tbl(input int idx, input int v, input bit busy);
    @(negedge clk);
    tbl_we_i  = 1'b1;
    tbl_sel_i = 2'(idx);
    tbl_val_i = 8'(v);
    @(negedge clk);
    tbl_we_i = 1'b0;
    if (!busy && legal(idx, v)) m_tbl[idx] = v;
  endtask

  task automatic run_op(input logic [DW-1:0] d, input logic [2:0] f,
                        input bit scramble, input bit busy_wr, input string tag);
    exp_t e;
    int   t;
    t = target(f);
    @(negedge clk);
    req_i  = 1'b1;
    data_i = d;
    slow_i = f;
    e.d = d; e.tier = t; e.at = cyc + 1 + t + 1 + m_tbl[t]; e.tag = tag;
    sb.push_back(e);
    if (scramble) begin
      @(negedge clk);
      data_i = ~d;   // R2
      slow_i = ~f;   // R5
    end
    if (busy_wr) wr_tbl(0, 1, 1);  // R9: in flight, must be dropped
    while (!done_o) @(negedge clk);
    repeat (2) @(negedge clk);
    check(done_o == 1'b1, "R6", "done held with req high", done_o, 1);
    req_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0, "R6", "done after req drop", done_o, 0);
    check(tier_o == 2'd0, "R6", "tier after req drop", tier_o, 0);
  endtask

  initial begin
    #(20 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
    check(tier_o == 2'd0, "R1", "tier after reset", tier_o, 0);
    check(data_o == '0,   "R1", "data after reset", data_o, 0);

    run_op(16'hA5A5, 3'b000, 0, 0, "R3");
    run_op(16'h1234, 3'b000, 1, 0, "R5");
    run_op(16'h0F0F, 3'b001, 0, 0, "R4");
    run_op(16'hBEEF, 3'b010, 1, 0, "R4");
    run_op(16'hC001, 3'b100, 0, 0, "R1");
    run_op(16'h5A5A, 3'b101, 1, 0, "R4");

    wr_tbl(3, 20, 0);
    run_op(16'h7777, 3'b100, 0, 0, "R7");

    wr_tbl(1, 1, 0);
    wr_tbl(2, 30, 0);
    wr_tbl(0, 0, 0);
    run_op(16'h2468, 3'b010, 0, 0, "R8");
    run_op(16'h1357, 3'b001, 0, 0, "R8");
    run_op(16'hFFFF, 3'b000, 0, 0, "R8");

    run_op(16'h4242, 3'b100, 0, 1, "R9");
    run_op(16'h0001, 3'b000, 0, 0, "R9");

    wr_tbl(0, 1, 0);
    run_op(16'h8000, 3'b000, 1, 0, "R7");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R3", "outstanding expectations", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule